// File: doc/BRIEF.md
# Fractional-Nanosecond Time Accumulator

This block keeps a free-running time-of-day count for precision timestamping. Every core clock cycle, while it is switched on, it adds a programmable step to an accumulator. The step is given in nanoseconds as 32.32 fixed point. The accumulator holds a 64-bit whole-nanosecond count and a 32-bit fraction below it. Whole and fractional time are exposed as separate registers.

Software drives the block over a plain 64-bit register bus: address, write strobe, write data, and registered read data. The clock rate is trimmed only by writing a new step value. The nominal step is (10^9 * 2^32) / f_clk. For a clock of N times 50 MHz this is 20/N ns.

Top module: `ptp_time_acc`

## Requirements
- R1: After reset the whole-nanosecond and fractional time are zero and the enable is clear. The step register holds the parameter `DEF_INC`, which defaults to 0x0000_0014_0000_0000 (20 ns).
- R2: While the enable is clear and no time register is written, neither time register changes.
- R3: While the enable is set, each clock edge adds the step to the 96-bit value {nanoseconds, fraction}. A carry out of the fraction enters the nanosecond count on that same edge.
- R4: The nanosecond count wraps modulo 2^64.
- R5: A write to offset 0xF10 loads the 64-bit nanosecond count. A write to offset 0xF08 loads the fraction from data bits 31:0. In that cycle the add is skipped and the other time part holds.
- R6: A write to offset 0xF18 replaces the step. The edge that performs the write still adds the old step, and every later edge adds the new one.
- R7: The read data registers the value addressed in the previous cycle, as it stood before that edge. Reads of 0xF10 and 0xF18 give all 64 bits.
- R8: The configuration word is at 0xF00 and bit 0 is the enable. A write to it sets the enable from data bit 0. It reads back as the enable in bit 0 with all other bits zero.
- R9: The fraction reads at 0xF08 in bits 31:0 with bits 63:32 zero.
- R10: Any other offset reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the address |

## Verification
Read data appears one rising edge after its address is presented. A written time value is visible at the rising edge that takes the write. A new step first shows in the time one edge later. The bench drives every bus cycle at the falling edge and computes the expected read value from its own 96-bit model before that edge. It then advances the model by the requirement rules, and compares 1 ns after the rising edge. Sweeps cover nominal steps for clock multipliers 1 to 16, fractional carry, 64-bit wrap, and load-versus-add collisions.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;
    localparam int NS_W   = 64;
    localparam int FRAC_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_FRAC = 12'hF08;
    localparam logic [ADDR_W-1:0] OFS_NS   = 12'hF10;
    localparam logic [ADDR_W-1:0] OFS_INC  = 12'hF18;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] inc;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/ptp_time_core.sv
module ptp_time_core #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int INC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INC_W-1:0]  inc,
    input  logic              ld_ns,
    input  logic              ld_frac,
    input  logic [NS_W-1:0]   ld_data,
    output logic [NS_W-1:0]   ns,
    output logic [FRAC_W-1:0] frac
);
    localparam int ACC_W = NS_W + FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ld_ns) begin
            c_d.acc[ACC_W-1:FRAC_W] = ld_data;
        end else if (ld_frac) begin
            c_d.acc[FRAC_W-1:0] = ld_data[FRAC_W-1:0];
        end else if (en) begin
            c_d.acc = c_q.acc + ACC_W'(inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ns   = c_q.acc[ACC_W-1:FRAC_W];
    assign frac = c_q.acc[FRAC_W-1:0];
endmodule

// File: rtl/ptp_time_regs.sv
module ptp_time_regs
    import ptp_time_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEF_INC = 64'h0000_0014_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NS_W-1:0]   ns,
    input  logic [FRAC_W-1:0] frac,
    output logic              en,
    output logic [DATA_W-1:0] inc,
    output logic              ld_ns,
    output logic              ld_frac,
    output logic [DATA_W-1:0] rdata
);
    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        ld_ns   = 1'b0;
        ld_frac = 1'b0;
        if (we) begin
            case (addr)
                OFS_CFG:  r_d.en  = wdata[0];
                OFS_INC:  r_d.inc = wdata;
                OFS_NS:   ld_ns   = 1'b1;
                OFS_FRAC: ld_frac = 1'b1;
                default:  ;
            endcase
        end
        case (addr)
            OFS_CFG:  r_d.rdata = DATA_W'(r_q.en);
            OFS_FRAC: r_d.rdata = DATA_W'(frac);
            OFS_NS:   r_d.rdata = DATA_W'(ns);
            OFS_INC:  r_d.rdata = r_q.inc;
            default:  r_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.en    <= 1'b0;
            r_q.inc   <= DEF_INC;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en    = r_q.en;
    assign inc   = r_q.inc;
    assign rdata = r_q.rdata;
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc
    import ptp_time_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEF_INC = 64'h0000_0014_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              en_w;
    logic [DATA_W-1:0] inc_w;
    logic              ld_ns_w;
    logic              ld_frac_w;
    logic [NS_W-1:0]   ns_w;
    logic [FRAC_W-1:0] frac_w;

    ptp_time_regs #(.DEF_INC(DEF_INC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .ns      (ns_w),
        .frac    (frac_w),
        .en      (en_w),
        .inc     (inc_w),
        .ld_ns   (ld_ns_w),
        .ld_frac (ld_frac_w),
        .rdata   (bus_rdata)
    );

    ptp_time_core #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .inc     (inc_w),
        .ld_ns   (ld_ns_w),
        .ld_frac (ld_frac_w),
        .ld_data (bus_wdata),
        .ns      (ns_w),
        .frac    (frac_w)
    );
endmodule

// File: rtl/ptp_time_acc_chk.sv
module ptp_time_acc_chk
    import ptp_time_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              en,
    input logic [DATA_W-1:0] inc,
    input logic [NS_W-1:0]   ns,
    input logic [FRAC_W-1:0] frac
);
    logic time_wr;
    logic mapped;
    assign time_wr = we && (addr == OFS_NS || addr == OFS_FRAC);
    assign mapped  = (addr == OFS_CFG) || (addr == OFS_FRAC) ||
                     (addr == OFS_NS)  || (addr == OFS_INC);

    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !time_wr) |=> ($stable(ns) && $stable(frac)));

    a_r3_step_add: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !time_wr) |=>
        ({ns, frac} == $past({ns, frac}) + (NS_W+FRAC_W)'($past(inc))));

    a_r5_load_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_NS) |=> (ns == $past(wdata)) && $stable(frac));

    a_r5_load_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_FRAC) |=> (frac == $past(wdata[FRAC_W-1:0])) && $stable(ns));

    a_r6_new_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_INC) |=> (inc == $past(wdata)));

    a_r8_cfg_read: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_CFG) |=> (rdata[DATA_W-1:1] == '0));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |=> (rdata == '0));
endmodule

bind ptp_time_acc ptp_time_acc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .en    (en_w),
    .inc   (inc_w),
    .ns    (ns_w),
    .frac  (frac_w)
);

// File: tb/sim_ptp_time_acc.sv
`timescale 1ns/1ps
module sim_ptp_time_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic        bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] DEF_STEP = 64'h0000_0014_0000_0000;

    // reference model state, advanced once per rising edge
    logic [95:0] m_acc;
    logic        m_en;
    logic [63:0] m_inc;

    always #5 clk = ~clk;

    ptp_time_acc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [63:0] model_read(input logic [11:0] a);
        case (a)
            12'hF00: return {63'b0, m_en};
            12'hF08: return {32'b0, m_acc[31:0]};
            12'hF10: return m_acc[95:32];
            12'hF18: return m_inc;
            default: return 64'h0;
        endcase
    endfunction

    task automatic cyc(input logic [11:0] a, input logic w, input logic [63:0] d,
                       input string tag);
        logic [63:0] exp;
        @(negedge clk);
        bus_addr  = a;
        bus_we    = w;
        bus_wdata = d;
        exp = model_read(a);
        @(posedge clk);
        if (w && (a == 12'hF10)) m_acc[95:32] = d;
        else if (w && (a == 12'hF08)) m_acc[31:0] = d[31:0];
        else if (m_en) m_acc = m_acc + {32'b0, m_inc};
        if (w && a == 12'hF00) m_en  = d[0];
        if (w && a == 12'hF18) m_inc = d;
        #1;
        if (!w) begin
            checks++;
            if (bus_rdata !== exp) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
            end
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(a, 1'b0, 64'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        cyc(a, 1'b1, d, "wr");
    endtask

    initial begin
        m_acc = '0;
        m_en  = 1'b0;
        m_inc = DEF_STEP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R9 fraction layout, R8 config layout
        rd(12'hF00, "R1");
        rd(12'hF08, "R1");
        rd(12'hF10, "R1");
        rd(12'hF18, "R1");
        // R10 unmapped reads
        rd(12'h000, "R10");
        rd(12'hF20, "R10");
        rd(12'hF04, "R10");
        rd(12'hFFF, "R10");

        // R2 hold while disabled
        for (int i = 0; i < 4; i++) rd(12'hF10, "R2");
        wr(12'hF10, 64'd1000);
        wr(12'hF08, 64'hFFFF_FFFF_0000_0123);
        for (int i = 0; i < 3; i++) rd(12'hF08, "R9");
        rd(12'hF10, "R2");

        // R8 config with junk upper bits, R3 counting
        wr(12'hF00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'hF00, "R8");
        for (int i = 0; i < 6; i++) rd(12'hF10, "R3");

        // R6 / R3 sweep nominal steps for multipliers 1..16
        for (int n = 1; n <= 16; n++) begin
            logic [63:0] step;
            step = (64'd1000000000 << 32) / (64'd50000000 * 64'(n));
            wr(12'hF18, step);
            rd(12'hF10, "R6");
            rd(12'hF18, "R6");
            for (int i = 0; i < 20; i++) begin
                rd(12'hF10, "R3");
                rd(12'hF08, "R3");
            end
        end

        // R3 fractional carry: half-nanosecond step
        wr(12'hF08, 64'h0000_0000_FFFF_FFFF);
        wr(12'hF18, 64'h0000_0000_8000_0000);
        for (int i = 0; i < 12; i++) begin
            rd(12'hF10, "R3");
            rd(12'hF08, "R3");
        end
        wr(12'hF18, 64'h0000_0000_0000_0001);
        wr(12'hF08, 64'h0000_0000_FFFF_FFFE);
        for (int i = 0; i < 4; i++) rd(12'hF10, "R3");

        // R4 wrap of nanosecond count
        wr(12'hF18, 64'h0000_0014_0000_0000);
        wr(12'hF10, 64'hFFFF_FFFF_FFFF_FFC0);
        for (int i = 0; i < 8; i++) rd(12'hF10, "R4");

        // R5 load while counting, neighbour holds, add skipped
        wr(12'hF10, 64'h0123_4567_89AB_CDEF);
        rd(12'hF10, "R5");
        rd(12'hF08, "R5");
        wr(12'hF08, 64'h0000_0000_DEAD_BEEF);
        rd(12'hF08, "R5");
        rd(12'hF10, "R5");

        // R10 writes to unmapped offsets change nothing
        wr(12'hF20, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h000, 64'h0);
        wr(12'hF0C, 64'h1234);
        rd(12'hF00, "R10");
        rd(12'hF18, "R10");
        rd(12'hF10, "R10");
        rd(12'hF08, "R10");

        // R8 disable through bit 0, R2 hold afterwards
        wr(12'hF00, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(12'hF00, "R8");
        for (int i = 0; i < 4; i++) rd(12'hF10, "R2");
        rd(12'hF08, "R2");

        // R7 back-to-back reads of different registers
        wr(12'hF00, 64'h1);
        for (int i = 0; i < 8; i++) begin
            rd(12'hF18, "R7");
            rd(12'hF10, "R7");
            rd(12'hF00, "R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule